// File: doc/BRIEF.md
# Write-enable and address-protect controller

This block sits behind the serial command receiver of a small non-volatile memory. Each time a command frame finishes (chip select falls), the receiver presents the two opcode bits, the address field and the two mode pins for one clock with `cmd_valid` high. The controller decodes the command and holds the write-enable latch, a one-shot arming flag for protect changes, the protect boundary register and a permanent lock. It decides whether a programming cycle may start. When one may, it raises `start_req` for one clock with an operation code for the programming sequencer. The sequencer's timing and the serial shifting are handled elsewhere.

Every address at or above the boundary is write-protected. Changing the boundary needs an arming command in the frame just before it. A lock command freezes the boundary for good. The arming and lock state lives in a three-state machine:

- `S_IDLE`: not armed. It moves to `S_ARMED` on an accepted protect-enable.
- `S_ARMED`: it moves to `S_FROZEN` on an accepted lock. It stays in `S_ARMED` on another accepted protect-enable. Any other command sends it back to `S_IDLE`.
- `S_FROZEN`: absorbing. Nothing leaves it.

The write-enable latch, the boundary and a "cleared since last protect write" flag are kept beside this machine. All of them are updated on the clock where `cmd_valid` is high.

Top module: `wprot_ctrl`

## Requirements
- R1: Opcode 01 with `sel_prot` low is an array write. It starts with code 1 only when `prog_en` is high, the write-enable latch is set, and either the address is below the boundary or the boundary is in its cleared state.
- R2: The write-enable latch is clear after reset. Opcode 00 with address bits [7:6]=11 and `sel_prot` low sets it. Opcode 00 with [7:6]=00 and `sel_prot` low clears it whatever `prog_en` is. The change takes effect for the next frame.
- R3: With `prog_en` low, no write, write-all, protect clear, protect write or lock starts. Write-enable and protect-enable also have no effect with `prog_en` low.
- R4: A write to an address at or above the boundary is refused. In the cleared state every address, including 255, is writable.
- R5: Opcode 00 with [7:6]=01 and `sel_prot` low is write-all. It starts with code 2 only with `prog_en` high, the latch set and the boundary in its cleared state.
- R6: Opcode 00 with [7:6]=11 and `sel_prot` high is protect-enable. It arms only with `prog_en` high and the latch set, and the arming lasts for the next frame only.
- R7: Opcode 11 with address 0xFF and `sel_prot` high is protect clear. When armed with `prog_en` high it starts with code 3, loads the boundary with 0xFF and enters the cleared state.
- R8: Opcode 01 with `sel_prot` high is protect write. It starts with code 4 and loads the boundary with the address only when armed, with `prog_en` high, and with a clear done since the last protect write. It leaves the cleared state.
- R9: Opcode 00 with address 0x00 and `sel_prot` high is lock. When armed with `prog_en` high it starts with code 5. After that, protect clear, protect write and lock never start again, and the boundary never changes.
- R10: Every frame other than an accepted protect-enable drops the arming. This includes reads (opcode 10), refused commands and undefined codes.
- R11: `start_req` is a one-clock pulse on the clock after the `cmd_valid` edge. `start_op` is 0 whenever `start_req` is low. Reads never start a cycle.
- R12: After reset the boundary reads 0xFF in the cleared state, the block is unlocked and not armed, and `start_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_valid | input | 1 | One-clock strobe: a command frame has ended |
| cmd_opc | input | 2 | Opcode bits of the frame |
| cmd_addr | input | AW | Address field of the frame |
| sel_prot | input | 1 | Mode pin: high selects protect-register operations |
| prog_en | input | 1 | Mode pin: high enables programming |
| start_req | output | 1 | Programming cycle start pulse |
| start_op | output | 3 | Operation: 1 write, 2 write-all, 3 protect clear, 4 protect write, 5 lock, 0 none |
| bound_out | output | AW | Current protect boundary (read-back path) |

## Verification
The bench probes address 255 while the boundary is in its cleared state. A design that compared only against the boundary would refuse that write. It places a read between an arming frame and a protect clear. A design whose arming survived other frames would start the clear. It tries a second protect write with no clear in between, and a design without the clear-before-write flag would move the boundary. It then tries clear, write and lock again after the lock, where any leak out of the frozen state shows up as a start pulse or a changed `bound_out`. It also checks that write-disable works with `prog_en` low, which a design gating every command on that pin would ignore.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [3:0] {
        C_NONE, C_READ, C_PREAD, C_WEN, C_WDS, C_WRALL,
        C_WRITE, C_PWRITE, C_PCLEAR, C_PEN, C_LOCK
    } cmd_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_WRALL  = 3'd2,
        OP_PCLR   = 3'd3,
        OP_PWR    = 3'd4,
        OP_LOCK   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARMED  = 2'd1,
        S_FROZEN = 2'd2
    } arm_state_e;

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
    import wprot_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [1:0]    opc,
    input  logic [AW-1:0] addr,
    input  logic          sel_prot,
    output cmd_e          cmd
);
    localparam logic [AW-1:0] ALL_ONES = '1;
    localparam logic [AW-1:0] ALL_ZERO = '0;

    logic [1:0] sub;
    assign sub = addr[AW-1:AW-2];

    always_comb begin
        cmd = C_NONE;
        unique case (opc)
            2'b10: cmd = sel_prot ? C_PREAD : C_READ;
            2'b01: cmd = sel_prot ? C_PWRITE : C_WRITE;
            2'b11: cmd = (sel_prot && addr == ALL_ONES) ? C_PCLEAR : C_NONE;
            2'b00: begin
                if (!sel_prot) begin
                    unique case (sub)
                        2'b11:   cmd = C_WEN;
                        2'b00:   cmd = C_WDS;
                        2'b01:   cmd = C_WRALL;
                        default: cmd = C_NONE;
                    endcase
                end else if (sub == 2'b11) begin
                    cmd = C_PEN;
                end else if (addr == ALL_ZERO) begin
                    cmd = C_LOCK;
                end else begin
                    cmd = C_NONE;
                end
            end
            default: cmd = C_NONE;
        endcase
    end
endmodule

// File: rtl/wprot_grant.sv
module wprot_grant
    import wprot_pkg::*;
#(
    parameter int AW = 8
) (
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr,
    input  logic          prog_en,
    input  logic          wel,
    input  logic          armed,
    input  logic          cleared,
    input  logic [AW-1:0] bound,
    output op_e           op,
    output logic          set_wel,
    output logic          clr_wel,
    output logic          arm_req
);
    logic below;
    assign below = (addr < bound) || cleared;

    always_comb begin
        op      = OP_NONE;
        set_wel = 1'b0;
        clr_wel = 1'b0;
        arm_req = 1'b0;
        unique case (cmd)
            C_WEN:    set_wel = prog_en;
            C_WDS:    clr_wel = 1'b1;
            C_WRITE:  if (prog_en && wel && below)   op = OP_WRITE;
            C_WRALL:  if (prog_en && wel && cleared) op = OP_WRALL;
            C_PEN:    arm_req = prog_en && wel;
            C_PCLEAR: if (prog_en && armed)            op = OP_PCLR;
            C_PWRITE: if (prog_en && armed && cleared) op = OP_PWR;
            C_LOCK:   if (prog_en && armed)            op = OP_LOCK;
            default:  op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_opc,
    input  logic [AW-1:0] cmd_addr,
    input  logic          sel_prot,
    input  logic          prog_en,
    output logic          start_req,
    output logic [2:0]    start_op,
    output logic [AW-1:0] bound_out
);
    localparam logic [AW-1:0] BOUND_CLEAR = '1;

    cmd_e          cmd;
    op_e           gop;
    logic          set_wel, clr_wel, arm_req;
    arm_state_e    state_q, state_d;
    logic          wel_q, clr_q, locked;
    logic [AW-1:0] bound_q;
    op_e           op_q;

    wprot_decode #(.AW(AW)) u_dec (
        .opc(cmd_opc), .addr(cmd_addr), .sel_prot(sel_prot), .cmd(cmd)
    );

    wprot_grant #(.AW(AW)) u_grant (
        .cmd(cmd), .addr(cmd_addr), .prog_en(prog_en), .wel(wel_q),
        .armed(state_q == S_ARMED), .cleared(clr_q), .bound(bound_q),
        .op(gop), .set_wel(set_wel), .clr_wel(clr_wel), .arm_req(arm_req)
    );

    // arming / lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (state_q)
                S_IDLE:   if (arm_req) state_d = S_ARMED;
                S_ARMED: begin
                    if (gop == OP_LOCK)  state_d = S_FROZEN;
                    else if (arm_req)    state_d = S_ARMED;
                    else                 state_d = S_IDLE;
                end
                S_FROZEN: state_d = S_FROZEN;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    assign locked = (state_q == S_FROZEN);

    // latch, boundary and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            clr_q   <= 1'b1;
            bound_q <= BOUND_CLEAR;
            op_q    <= OP_NONE;
        end else begin
            op_q <= OP_NONE;
            if (cmd_valid) begin
                op_q <= gop;
                if (set_wel) wel_q <= 1'b1;
                if (clr_wel) wel_q <= 1'b0;
                if (gop == OP_PCLR) begin
                    bound_q <= BOUND_CLEAR;
                    clr_q   <= 1'b1;
                end
                if (gop == OP_PWR) begin
                    bound_q <= cmd_addr;
                    clr_q   <= 1'b0;
                end
            end
        end
    end

    assign start_req = (op_q != OP_NONE);
    assign start_op  = op_q;
    assign bound_out = bound_q;
endmodule

// File: rtl/wprot_chk.sv
module wprot_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          start_req,
    input logic [2:0]    start_op,
    input logic [AW-1:0] bound_out,
    input logic          wel,
    input logic          locked
);
    // R11
    pulse_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> $past(cmd_valid));

    // R11
    op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req |-> start_op == 3'd0);

    // R11
    op_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (start_op != 3'd0 && start_op <= 3'd5));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R9
    frozen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(bound_out));

    // R1
    write_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_op == 3'd1) |-> $past(wel));

    // R8
    bound_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(bound_out));
endmodule

bind wprot_ctrl wprot_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .start_req(start_req),
    .start_op(start_op), .bound_out(bound_out), .wel(wel_q), .locked(locked)
);

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_opc = 2'b00;
    logic [7:0] cmd_addr = 8'h00;
    logic       sel_prot = 1'b0;
    logic       prog_en = 1'b0;
    logic       start_req;
    logic [2:0] start_op;
    logic [7:0] bound_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R12";

    // reference model state
    bit m_wel = 0, m_armed = 0, m_locked = 0, m_clr = 1;
    int m_bound = 255;
    bit exp_start = 0;
    int exp_op = 0;
    int exp_bound = 255;

    always #2 clk = ~clk;

    wprot_ctrl #(.AW(8)) u_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opc(cmd_opc),
        .cmd_addr(cmd_addr), .sel_prot(sel_prot), .prog_en(prog_en),
        .start_req(start_req), .start_op(start_op), .bound_out(bound_out)
    );

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (start_req !== exp_start || int'(start_op) != exp_op ||
                int'(bound_out) != exp_bound) begin
                errors++;
                $display("FAIL %s: start=%0b op=%0d bound=%0d expected start=%0b op=%0d bound=%0d",
                         cur_req, start_req, start_op, bound_out, exp_start, exp_op, exp_bound);
            end
        end
    end

    task automatic cmd(input logic [1:0] opc, input logic [7:0] a,
                       input logic pre, input logic pe, input string req);
        bit wen, wds, wrall, pen, lock, wr, pwr, pclr;
        int op;
        bit arm_next;
        @(negedge clk);
        cur_req   = req;
        cmd_valid = 1'b1;
        cmd_opc   = opc;
        cmd_addr  = a;
        sel_prot  = pre;
        prog_en   = pe;
        wen   = (opc == 2'b00) && !pre && (a[7:6] == 2'b11);
        wds   = (opc == 2'b00) && !pre && (a[7:6] == 2'b00);
        wrall = (opc == 2'b00) && !pre && (a[7:6] == 2'b01);
        pen   = (opc == 2'b00) && pre && (a[7:6] == 2'b11);
        lock  = (opc == 2'b00) && pre && (a == 8'h00);
        wr    = (opc == 2'b01) && !pre;
        pwr   = (opc == 2'b01) && pre;
        pclr  = (opc == 2'b11) && pre && (a == 8'hFF);
        op = 0;
        arm_next = 0;
        if (wr && pe && m_wel && (int'(a) < m_bound || m_clr)) op = 1;
        if (wrall && pe && m_wel && m_clr) op = 2;
        if (pclr && pe && m_armed && !m_locked) op = 3;
        if (pwr && pe && m_armed && !m_locked && m_clr) op = 4;
        if (lock && pe && m_armed && !m_locked) op = 5;
        if (pen && pe && m_wel) arm_next = 1;
        if (wen && pe) m_wel = 1;
        if (wds) m_wel = 0;
        if (op == 3) begin m_bound = 255; m_clr = 1; end
        if (op == 4) begin m_bound = int'(a); m_clr = 0; end
        if (op == 5) m_locked = 1;
        m_armed = arm_next;
        @(posedge clk);
        #1;
        exp_start = (op != 0);
        exp_op    = op;
        exp_bound = m_bound;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk);
        #1;
        exp_start = 0;
        exp_op    = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R12: reset state
        checks++;
        if (start_req !== 1'b0 || start_op !== 3'd0 || bound_out !== 8'hFF) begin
            errors++;
            $display("FAIL R12: start=%0b op=%0d bound=%0d expected start=0 op=0 bound=255",
                     start_req, start_op, bound_out);
        end
        rst_n = 1'b1;
        cmd(2'b01, 8'h05, 0, 1, "R2");      // write before write-enable: refused
        cmd(2'b00, 8'hC0, 0, 0, "R3");      // write-enable with prog_en low
        cmd(2'b01, 8'h05, 0, 1, "R3");      // still refused
        cmd(2'b00, 8'hC0, 0, 1, "R2");      // write-enable
        cmd(2'b01, 8'h05, 0, 1, "R1");      // write accepted
        cmd(2'b01, 8'h06, 0, 0, "R3");      // prog_en low blocks write
        cmd(2'b10, 8'h05, 0, 1, "R11");     // read never starts
        cmd(2'b01, 8'hFF, 0, 1, "R4");      // top address writable when cleared
        cmd(2'b00, 8'h40, 0, 1, "R5");      // write-all accepted
        cmd(2'b00, 8'hC0, 1, 1, "R6");      // protect-enable
        cmd(2'b10, 8'h00, 1, 1, "R10");     // protect read drops arming
        cmd(2'b11, 8'hFF, 1, 1, "R10");     // clear refused
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b00, 8'hC0, 1, 1, "R6");      // re-arm
        cmd(2'b11, 8'hFF, 1, 1, "R7");      // clear accepted
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b01, 8'h80, 1, 1, "R8");      // boundary 0x80
        cmd(2'b01, 8'h80, 0, 1, "R4");      // at boundary: refused
        cmd(2'b01, 8'hFF, 0, 1, "R4");      // above: refused
        cmd(2'b01, 8'h7F, 0, 1, "R4");      // below: accepted
        cmd(2'b00, 8'h7F, 0, 1, "R5");      // write-all refused, not cleared
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b01, 8'h40, 1, 1, "R8");      // no clear since last protect write
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b00, 8'h00, 1, 0, "R3");      // lock with prog_en low refused
        cmd(2'b00, 8'h00, 1, 1, "R10");     // arming already spent
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b11, 8'hFE, 1, 1, "R10");     // undefined code drops arming
        cmd(2'b11, 8'hFF, 1, 1, "R10");
        cmd(2'b00, 8'h00, 0, 0, "R2");      // write-disable with prog_en low
        cmd(2'b01, 8'h10, 0, 1, "R2");      // refused
        cmd(2'b00, 8'hC0, 1, 1, "R6");      // protect-enable needs latch: refused
        cmd(2'b11, 8'hFF, 1, 1, "R6");
        cmd(2'b00, 8'hC0, 0, 1, "R2");
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b11, 8'hFF, 1, 1, "R7");
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b01, 8'h20, 1, 1, "R8");
        cmd(2'b00, 8'hC0, 1, 1, "R6");
        cmd(2'b00, 8'h00, 1, 1, "R9");      // lock
        cmd(2'b00, 8'hC0, 1, 1, "R9");
        cmd(2'b11, 8'hFF, 1, 1, "R9");      // clear refused after lock
        cmd(2'b00, 8'hC0, 1, 1, "R9");
        cmd(2'b01, 8'h90, 1, 1, "R9");      // protect write refused
        cmd(2'b00, 8'hC0, 1, 1, "R9");
        cmd(2'b00, 8'h00, 1, 1, "R9");      // lock refused
        cmd(2'b01, 8'h1F, 0, 1, "R1");      // below frozen boundary: accepted
        cmd(2'b01, 8'h20, 0, 1, "R4");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule